// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides when a waiting thread block may start there. Each incoming request gives the threads in the block, the registers each thread needs and the shared memory bytes the block needs. Requests go into a small in-order queue. The head of the queue is admitted only when four separate budgets all have room: thread slots, resident-block slots, register-file entries and shared-memory bytes. The tightest of the four decides.

Demand is booked and returned per block, never per thread. An admitted block gets a slot number. The slot remembers the block's whole demand, and a completion pulse naming that slot returns all of it at once. A request that could never fit, even on an empty multiprocessor, is discarded with an error pulse so that the queue cannot lock up. The block keeps live usage counters and an active-warp count for occupancy readout.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After reset all usage counters and the active-warp count are zero, no grant or error pulse is shown, and `req_ready` is 1.
- R2: The total threads of resident blocks never exceeds MAX_THREADS (default 1536). A head block whose threads would cross that limit waits.
- R3: At most MAX_BLOCKS (default 8) blocks are resident, even when threads and other budgets still have room.
- R4: A block needs threads × registers-per-thread register entries, booked as one amount. The resident total never exceeds REG_CAP (default 16384). With 256 threads at 11 registers each, only five blocks fit.
- R5: Shared memory is booked per block, and the resident total never exceeds SMEM_CAP (default 49152 bytes).
- R6: Requests are served strictly in arrival order. A head that does not fit blocks every later request, even one that would fit, until resources are freed.
- R7: A completion pulse on a busy slot returns exactly that block's demand on all budgets. A completion on an idle slot changes nothing.
- R8: When a completion and an admission fall in the same cycle, the release is applied first, so the freed room and the freed slot are available to the head request.
- R9: A head request is discarded with a one-cycle `drop_err` pulse, and books nothing, when it has zero threads or when any single demand exceeds its whole capacity.
- R10: `act_warps` equals the sum over resident blocks of ceil(threads / WARP), where WARP is 32 by default. A block of 33 threads counts as 2 warps.
- R11: A grant appears as a one-cycle `grant_valid` pulse one clock edge after the head was evaluated. It comes with `grant_slot` set to the lowest-numbered free slot, and the counters reflect the new block in the same cycle.
- R12: `req_ready` is 0 while the queue holds QDEPTH (default 4) waiting requests. A request offered while `req_ready` is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Offer a new block request this cycle |
| req_threads | input | 12 | Threads in the requested block |
| req_rpt | input | 8 | Registers needed per thread |
| req_smem | input | 17 | Shared memory bytes for the block |
| req_ready | output | 1 | Queue has room for a request |
| done_valid | input | 1 | A resident block has completed |
| done_slot | input | 3 | Slot number of the completed block |
| grant_valid | output | 1 | Head request was admitted |
| grant_slot | output | 3 | Slot given to the admitted block |
| drop_err | output | 1 | Head request was discarded as impossible |
| res_threads | output | 24 | Threads of resident blocks |
| res_blocks | output | 4 | Number of resident blocks |
| res_regs | output | 24 | Register entries booked |
| res_smem | output | 24 | Shared memory bytes booked |
| act_warps | output | 24 | Active warps of resident blocks |

## Verification
Wrong internal state shows up at the ports on the next clock edge. A slot record that keeps the wrong demand makes the counters differ after that slot's completion. A wrong fit decision shows as a grant pulse too early or too late, or as a counter above its cap. Queue-order mistakes show as a later, smaller block getting a grant while the head waits. Same-cycle release errors show as a one-cycle delay of the grant that follows a completion.

// File: rtl/admit_pkg.sv
// Shared widths and record types for the admission controller.
// Assumes every capacity parameter of the top fits in AW bits.
package admit_pkg;
    localparam int TW = 12;   // threads per block field
    localparam int RW = 8;    // registers per thread field
    localparam int SW = 17;   // shared bytes per block field
    localparam int AW = 24;   // accounting width

    typedef struct packed {
        logic [TW-1:0] threads;
        logic [RW-1:0] rpt;
        logic [SW-1:0] smem;
    } blk_req_t;

    typedef struct packed {
        logic [AW-1:0] threads;
        logic [AW-1:0] regs;
        logic [AW-1:0] smem;
        logic [AW-1:0] warps;
    } blk_dem_t;

    // Whole-block demand derived from a raw request.
    function automatic blk_dem_t demand_of(blk_req_t r, int unsigned warp);
        blk_dem_t d;
        d.threads = AW'(r.threads);
        d.regs    = AW'(r.threads) * AW'(r.rpt);
        d.smem    = AW'(r.smem);
        d.warps   = (AW'(r.threads) + AW'(warp - 1)) / AW'(warp);
        return d;
    endfunction
endpackage

// File: rtl/adm_req_fifo.sv
// In-order request queue. Assumes the caller pushes only when not full
// and pops only when not empty. Storage is not reset; only pointers are.
module adm_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Write the incoming entry into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/adm_slot_table.sv
// Resident-block slots. Each slot holds the full demand of the block placed
// in it. A completion on a busy slot yields that demand for release. Free-slot
// search sees a slot released this cycle as free, and allocation wins over
// release on the same slot.
module adm_slot_table
    import admit_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_req,
    input  logic [SLOT_W-1:0] rel_idx,
    input  logic              alloc_en,
    input  blk_dem_t          alloc_dem,
    output logic              rel_en,
    output blk_dem_t          rel_dem,
    output logic              free_ok,
    output logic [SLOT_W-1:0] free_idx
);
    logic     busy  [NSLOT];
    logic     avail [NSLOT];
    blk_dem_t dem   [NSLOT];

    // Resolve the release target and pick the lowest free slot.
    always_comb begin
        rel_en   = 1'b0;
        rel_dem  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rel_req && rel_idx == SLOT_W'(i) && busy[i]) begin
                rel_en  = 1'b1;
                rel_dem = dem[i];
            end
        end
        for (int i = 0; i < NSLOT; i++)
            avail[i] = !busy[i] || (rel_en && rel_idx == SLOT_W'(i));
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (avail[i]) begin
                free_ok  = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Hold one block's booking; fill on grant, clear on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[g] <= 1'b0;
                dem[g]  <= '0;
            end else if (alloc_en && free_idx == SLOT_W'(g)) begin
                busy[g] <= 1'b1;
                dem[g]  <= alloc_dem;
            end else if (rel_en && rel_idx == SLOT_W'(g)) begin
                busy[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adm_ledger.sv
// Usage counters for the four budgets plus active warps. Fit and too-big
// tests are made against the counters after this cycle's release.
// Assumes at most one release and one allocation per cycle.
module adm_ledger
    import admit_pkg::*;
#(
    parameter int MAX_THREADS = 1536,
    parameter int MAX_BLOCKS  = 8,
    parameter int REG_CAP     = 16384,
    parameter int SMEM_CAP    = 49152,
    parameter int BLK_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_en,
    input  blk_dem_t         rel_dem,
    input  logic             alloc_en,
    input  blk_dem_t         alloc_dem,
    input  blk_dem_t         head_dem,
    output logic             fit_ok,
    output logic             too_big,
    output logic [AW-1:0]    used_threads,
    output logic [AW-1:0]    used_regs,
    output logic [AW-1:0]    used_smem,
    output logic [AW-1:0]    used_warps,
    output logic [BLK_W-1:0] used_blocks
);
    localparam logic [AW-1:0] CAP_T = AW'(MAX_THREADS);
    localparam logic [AW-1:0] CAP_R = AW'(REG_CAP);
    localparam logic [AW-1:0] CAP_S = AW'(SMEM_CAP);

    blk_dem_t         after;
    logic [BLK_W-1:0] after_blocks;

    // Usage once this cycle's release is taken out.
    always_comb begin
        after.threads = used_threads - (rel_en ? rel_dem.threads : '0);
        after.regs    = used_regs    - (rel_en ? rel_dem.regs    : '0);
        after.smem    = used_smem    - (rel_en ? rel_dem.smem    : '0);
        after.warps   = used_warps   - (rel_en ? rel_dem.warps   : '0);
        after_blocks  = used_blocks  - BLK_W'(rel_en);
    end

    // Room and feasibility tests for the head request.
    always_comb begin
        fit_ok  = (after.threads + head_dem.threads <= CAP_T) &&
                  (after.regs    + head_dem.regs    <= CAP_R) &&
                  (after.smem    + head_dem.smem    <= CAP_S);
        too_big = (head_dem.threads == '0)   ||
                  (head_dem.threads > CAP_T) ||
                  (head_dem.regs    > CAP_R) ||
                  (head_dem.smem    > CAP_S);
    end

    // Book the new block on top of the post-release usage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_threads <= '0;
            used_regs    <= '0;
            used_smem    <= '0;
            used_warps   <= '0;
            used_blocks  <= '0;
        end else if (alloc_en) begin
            used_threads <= after.threads + alloc_dem.threads;
            used_regs    <= after.regs    + alloc_dem.regs;
            used_smem    <= after.smem    + alloc_dem.smem;
            used_warps   <= after.warps   + alloc_dem.warps;
            used_blocks  <= after_blocks  + 1'b1;
        end else begin
            used_threads <= after.threads;
            used_regs    <= after.regs;
            used_smem    <= after.smem;
            used_warps   <= after.warps;
            used_blocks  <= after_blocks;
        end
    end
endmodule

// File: rtl/blk_admit_ctrl.sv
// Thread block admission for one multiprocessor. Queues requests in order,
// admits the head when thread, slot, register and shared-memory budgets all
// have room, discards heads that can never fit, and returns a block's full
// booking on its completion pulse. Release is applied before admission.
module blk_admit_ctrl
    import admit_pkg::*;
#(
    parameter int MAX_THREADS = 1536,
    parameter int MAX_BLOCKS  = 8,
    parameter int REG_CAP     = 16384,
    parameter int SMEM_CAP    = 49152,
    parameter int WARP        = 32,
    parameter int QDEPTH      = 4,
    localparam int SLOT_W     = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
    localparam int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TW-1:0]     req_threads,
    input  logic [RW-1:0]     req_rpt,
    input  logic [SW-1:0]     req_smem,
    output logic              req_ready,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              grant_valid,
    output logic [SLOT_W-1:0] grant_slot,
    output logic              drop_err,
    output logic [AW-1:0]     res_threads,
    output logic [BLK_W-1:0]  res_blocks,
    output logic [AW-1:0]     res_regs,
    output logic [AW-1:0]     res_smem,
    output logic [AW-1:0]     act_warps
);
    blk_req_t          in_req, head_req;
    blk_dem_t          head_dem, rel_dem;
    logic              q_empty, q_full, q_push, q_pop;
    logic              rel_en, free_ok, fit_ok, too_big;
    logic              do_grant, do_drop;
    logic [SLOT_W-1:0] free_idx;

    assign in_req    = '{threads: req_threads, rpt: req_rpt, smem: req_smem};
    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full;
    assign head_dem  = demand_of(head_req, WARP);
    assign do_drop   = !q_empty && too_big;
    assign do_grant  = !q_empty && !too_big && fit_ok && free_ok;
    assign q_pop     = do_drop || do_grant;

    adm_req_fifo #(.DEPTH(QDEPTH), .W($bits(blk_req_t))) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (in_req),
        .pop   (q_pop),
        .dout  (head_req),
        .empty (q_empty),
        .full  (q_full)
    );

    adm_slot_table #(.NSLOT(MAX_BLOCKS), .SLOT_W(SLOT_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_req   (done_valid),
        .rel_idx   (done_slot),
        .alloc_en  (do_grant),
        .alloc_dem (head_dem),
        .rel_en    (rel_en),
        .rel_dem   (rel_dem),
        .free_ok   (free_ok),
        .free_idx  (free_idx)
    );

    adm_ledger #(
        .MAX_THREADS (MAX_THREADS),
        .MAX_BLOCKS  (MAX_BLOCKS),
        .REG_CAP     (REG_CAP),
        .SMEM_CAP    (SMEM_CAP),
        .BLK_W       (BLK_W)
    ) u_ledger (
        .clk          (clk),
        .rst_n        (rst_n),
        .rel_en       (rel_en),
        .rel_dem      (rel_dem),
        .alloc_en     (do_grant),
        .alloc_dem    (head_dem),
        .head_dem     (head_dem),
        .fit_ok       (fit_ok),
        .too_big      (too_big),
        .used_threads (res_threads),
        .used_regs    (res_regs),
        .used_smem    (res_smem),
        .used_warps   (act_warps),
        .used_blocks  (res_blocks)
    );

    // Register the per-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_slot  <= '0;
            drop_err    <= 1'b0;
        end else begin
            grant_valid <= do_grant;
            grant_slot  <= free_idx;
            drop_err    <= do_drop;
        end
    end
endmodule

// File: rtl/adm_chk.sv
// Checker for blk_admit_ctrl: budget caps, outcome exclusivity, booking
// steps and warp bookkeeping, observed on the top's ports.
module adm_chk
    import admit_pkg::*;
#(
    parameter int MAX_THREADS = 1536,
    parameter int MAX_BLOCKS  = 8,
    parameter int REG_CAP     = 16384,
    parameter int SMEM_CAP    = 49152,
    parameter int WARP        = 32,
    localparam int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_valid,
    input logic             grant_valid,
    input logic             drop_err,
    input logic [AW-1:0]    res_threads,
    input logic [BLK_W-1:0] res_blocks,
    input logic [AW-1:0]    res_regs,
    input logic [AW-1:0]    res_smem,
    input logic [AW-1:0]    act_warps
);
    AST_THREAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        res_threads <= AW'(MAX_THREADS)); // R2
    AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        res_blocks <= BLK_W'(MAX_BLOCKS)); // R3
    AST_REG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        res_regs <= AW'(REG_CAP)); // R4
    AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        res_smem <= AW'(SMEM_CAP)); // R5
    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_blocks == '0 |-> (res_threads == '0 && res_regs == '0 && res_smem == '0)); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && drop_err)); // R9
    AST_DROP_BOOKS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err && !$past(done_valid) |-> $stable(res_blocks) && $stable(res_regs)); // R9
    AST_WARP_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        32'(act_warps) * 32'(WARP) >= 32'(res_threads)); // R10
    AST_GRANT_BOOKS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !$past(done_valid) |-> res_blocks == $past(res_blocks) + 1'b1); // R11
endmodule

bind blk_admit_ctrl adm_chk #(
    .MAX_THREADS (MAX_THREADS),
    .MAX_BLOCKS  (MAX_BLOCKS),
    .REG_CAP     (REG_CAP),
    .SMEM_CAP    (SMEM_CAP),
    .WARP        (WARP)
) u_adm_chk (.*);

// File: tb/test_blk_admit_ctrl.sv
// Directed corners plus seeded random traffic, compared each cycle with a
// bench model built from the requirements.
module test_blk_admit_ctrl;
    import admit_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int LT = 1536, LB = 8, LR = 16384, LS = 49152, LW = 32, LQ = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, done_valid = 1'b0;
    logic [TW-1:0] req_threads = '0;
    logic [RW-1:0] req_rpt = '0;
    logic [SW-1:0] req_smem = '0;
    logic [2:0]    done_slot = '0, grant_slot;
    logic          req_ready, grant_valid, drop_err;
    logic [AW-1:0] res_threads, res_regs, res_smem, act_warps;
    logic [3:0]    res_blocks;

    blk_admit_ctrl #(.MAX_THREADS(LT), .MAX_BLOCKS(LB), .REG_CAP(LR),
                     .SMEM_CAP(LS), .WARP(LW), .QDEPTH(LQ)) i_blk_admit_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
        .req_rpt(req_rpt), .req_smem(req_smem), .req_ready(req_ready),
        .done_valid(done_valid), .done_slot(done_slot), .grant_valid(grant_valid),
        .grant_slot(grant_slot), .drop_err(drop_err), .res_threads(res_threads),
        .res_blocks(res_blocks), .res_regs(res_regs), .res_smem(res_smem),
        .act_warps(act_warps));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_err = 0, n_drop = 0;
    int mq_t [LQ], mq_r [LQ], mq_s [LQ];
    int mq_n = 0;
    bit sb [LB];
    int st [LB], sr [LB], ss [LB];
    int e_gv = 0, e_gs = 0, e_dr = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sum_t();
        int s = 0;
        for (int i = 0; i < LB; i++) if (sb[i]) s += st[i];
        return s;
    endfunction
    function automatic int sum_r();
        int s = 0;
        for (int i = 0; i < LB; i++) if (sb[i]) s += sr[i];
        return s;
    endfunction
    function automatic int sum_s();
        int s = 0;
        for (int i = 0; i < LB; i++) if (sb[i]) s += ss[i];
        return s;
    endfunction
    function automatic int sum_b();
        int s = 0;
        for (int i = 0; i < LB; i++) if (sb[i]) s++;
        return s;
    endfunction
    function automatic int sum_w();
        int s = 0;
        for (int i = 0; i < LB; i++) if (sb[i]) s += (st[i] + LW - 1) / LW;
        return s;
    endfunction

    // Model one clock edge: release first, then head decision, then push.
    task automatic model_edge(bit v, int t, int r, int s, bit dv, int ds);
        int n_before, ht, hr, hs, fi;
        bit pop;
        n_before = mq_n;
        pop = 1'b0;
        e_gv = 0;
        e_dr = 0;
        if (dv && sb[ds]) sb[ds] = 1'b0;
        if (mq_n > 0) begin
            ht = mq_t[0];
            hr = mq_t[0] * mq_r[0];
            hs = mq_s[0];
            if (ht == 0 || ht > LT || hr > LR || hs > LS) begin
                e_dr = 1;
                pop = 1'b1;
            end else begin
                fi = -1;
                for (int i = LB - 1; i >= 0; i--) if (!sb[i]) fi = i;
                if (fi >= 0 && sum_t() + ht <= LT && sum_r() + hr <= LR && sum_s() + hs <= LS) begin
                    sb[fi] = 1'b1;
                    st[fi] = ht;
                    sr[fi] = hr;
                    ss[fi] = hs;
                    e_gv = 1;
                    e_gs = fi;
                    pop = 1'b1;
                end
            end
        end
        if (pop) begin
            for (int i = 0; i < LQ - 1; i++) begin
                mq_t[i] = mq_t[i + 1];
                mq_r[i] = mq_r[i + 1];
                mq_s[i] = mq_s[i + 1];
            end
            mq_n--;
        end
        if (v && n_before < LQ) begin
            mq_t[mq_n] = t;
            mq_r[mq_n] = r;
            mq_s[mq_n] = s;
            mq_n++;
        end
    endtask

    task automatic compare_all();
        chk("R6 grant order", int'(grant_valid), e_gv);
        if (e_gv != 0) chk("R11 lowest slot", int'(grant_slot), e_gs);
        chk("R9 drop pulse", int'(drop_err), e_dr);
        chk("R2 threads", int'(res_threads), sum_t());
        chk("R3 blocks", int'(res_blocks), sum_b());
        chk("R4 registers", int'(res_regs), sum_r());
        chk("R5 shared mem", int'(res_smem), sum_s());
        chk("R10 warps", int'(act_warps), sum_w());
        chk("R12 ready", int'(req_ready), (mq_n < LQ) ? 1 : 0);
    endtask

    // One cycle of stimulus, entered and left at a falling edge.
    task automatic step(bit v, int t, int r, int s, bit dv, int ds);
        req_valid   = v;
        req_threads = TW'(t);
        req_rpt     = RW'(r);
        req_smem    = SW'(s);
        done_valid  = dv;
        done_slot   = 3'(ds);
        model_edge(v, t, r, s, dv, ds);
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        done_valid = 1'b0;
        compare_all();
        if (drop_err) n_drop++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic release_all(int passes);
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < LB; i++) step(0, 0, 0, 0, 1, i);
            idle(3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int t, r, s, ds;
        bit v, dv;
        void'($urandom(32'd4711));
        for (int i = 0; i < LB; i++) sb[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 threads", int'(res_threads), 0);
        chk("R1 blocks", int'(res_blocks), 0);
        chk("R1 warps", int'(act_warps), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 grant", int'(grant_valid), 0);

        // R4 register budget: 256x11 fits five times
        for (int i = 0; i < 6; i++) step(1, 256, 11, 0, 0, 0);
        idle(8);
        chk("R4 five blocks", int'(res_blocks), 5);
        chk("R4 reg total", int'(res_regs), 14080);
        chk("R10 warps 5x8", int'(act_warps), 40);
        // R6 no bypass by a small block
        step(1, 32, 1, 0, 0, 0);
        idle(4);
        chk("R6 head blocks", int'(res_blocks), 5);
        // R8 release first
        step(0, 0, 0, 0, 1, 0);
        chk("R8 same-cycle grant", int'(grant_valid), 1);
        chk("R8 reused slot", int'(grant_slot), 0);
        chk("R8 regs", int'(res_regs), 14080);
        idle(1);
        chk("R11 next slot", int'(grant_slot), 5);
        chk("R2 threads", int'(res_threads), 1312);
        chk("R10 warps", int'(act_warps), 41);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, i);
        idle(2);
        chk("R7 all returned", int'(res_regs), 0);

        // R3 block-slot limit
        for (int i = 0; i < 9; i++) step(1, 32, 1, 0, 0, 0);
        idle(12);
        chk("R3 eight blocks", int'(res_blocks), 8);
        chk("R3 threads", int'(res_threads), 256);
        step(0, 0, 0, 0, 1, 3);
        chk("R3 ninth into slot", int'(grant_slot), 3);
        release_all(1);
        chk("R7 empty", int'(res_blocks), 0);

        // R2 thread limit and R12 queue full
        for (int i = 0; i < 4; i++) step(1, 512, 1, 100, 0, 0);
        idle(8);
        chk("R2 thread cap", int'(res_threads), 1536);
        chk("R5 smem", int'(res_smem), 300);
        for (int i = 0; i < 3; i++) step(1, 32, 1, 0, 0, 0);
        chk("R12 full", int'(req_ready), 0);
        release_all(2);
        chk("R7 drained", int'(res_blocks), 0);

        // R9 impossible requests
        n_drop = 0;
        step(1, 2000, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0);
        step(1, 32, 1, 60000, 0, 0);
        step(1, 256, 100, 0, 0, 0);
        idle(4);
        chk("R9 drop count", n_drop, 4);
        chk("R9 nothing booked", int'(res_blocks), 0);

        // R7 completion on an idle slot
        step(1, 64, 2, 0, 0, 0);
        idle(3);
        step(0, 0, 0, 0, 1, 5);
        chk("R7 idle slot threads", int'(res_threads), 64);
        chk("R7 idle slot regs", int'(res_regs), 128);
        step(0, 0, 0, 0, 1, 0);
        // R10 rounding
        step(1, 33, 1, 0, 0, 0);
        idle(3);
        chk("R10 33 threads", int'(act_warps), 2);
        step(0, 0, 0, 0, 1, 0);

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            v = ($urandom % 2) == 0;
            t = 1 + ($urandom % 512);
            if ($urandom % 25 == 0) t = ($urandom % 2 == 0) ? 0 : 1600 + ($urandom % 400);
            r = 1 + ($urandom % 32);
            s = $urandom % 16384;
            if ($urandom % 30 == 0) s = 50000 + ($urandom % 10000);
            dv = ($urandom % 10) < 3;
            ds = $urandom % LB;
            step(v, t, r, s, dv, ds);
        end
        release_all(6);
        chk("R7 final empty", int'(res_blocks), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule